// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block decodes a 24-bit bus address into a set of active-low select lines, one per channel. Channel 0 is the boot channel. It comes out of reset already enabled, so a processor can fetch its first instructions from a memory at address zero. The other channels stay idle until software programs them. Each channel holds a two-bit pin mode, a base register that carries an aligned base address and a block size, and an option register. The option register narrows the match by byte lane, transfer direction, address space and interrupt level. It also chooses which strobe times the select and how the bus cycle is terminated.

For every bus cycle the unit compares the address and the cycle qualifiers against each channel at the same time. Each channel that matches pulls its select low. When several channels match, the lowest-numbered one sets the termination. The unit counts wait clocks for that channel and raises an internal transfer acknowledge. It also reports whether the port is 16 bits wide and whether an autovector is requested. A pin that is not in a select mode can instead drive a bit of a port data register. All settings are loaded through a simple write port that takes a channel, a register selector and a 16-bit word.

Top module: `csel_unit`

## Requirements
- R1: After reset, every cs_n bit is high, and ack, ack_wide, avec_req and disc_out are all zero. Channel 0 leaves reset as a 16-bit select (pin mode 11), with base 0 and block code 7 (1M). Its option is set to: both lanes, read and write, address strobe timing, 13 wait states, user or supervisor space.
- R2: Each channel has a pin mode (cfg_sel 00, data bits 1:0). Only modes 10 (8-bit port) and 11 (16-bit port) can drive the channel's cs_n low. Mode 00 drives disc_out[ch] from bit ch of the port data register. Modes 01, 10 and 11 hold disc_out[ch] at 0.
- R3: The base register (cfg_sel 01) holds the address bits 23:11 in register bits 15:3, and a block code in bits 2:0. Codes 0 to 7 select 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M. Only the address bits at or above log2(block size) are compared, so a block is aligned to its size.
- R4: Option bits 14:13 pick the byte lanes. 00 never matches. 01 matches when the lower lane is accessed. 10 matches when the upper lane is accessed. 11 matches when either lane is accessed.
- R5: Option bits 12:11 pick the direction. 00 never matches. 01 matches reads only (bus_rw=1). 10 matches writes only. 11 matches both.
- R6: Option bits 5:4 pick the address space. 00 matches CPU-space cycles (bus_cpu=1), and only when option bits 3:1 are 0 or equal bus_ipl. 01 matches user cycles, 10 matches supervisor cycles, and 11 matches either kind of non-CPU cycle. Option bit 0 on the winning channel raises avec_req, but only in a CPU-space cycle.
- R7: Option bit 10 chooses the strobe that times the select: 0 uses bus_as and 1 uses bus_ds. cs_n is registered. It goes low one clock after the chosen strobe is sampled high while the channel matches. It returns high one clock after both strobes are sampled low.
- R8: Option bits 9:6 set the termination. A value n from 0 to 13 raises ack after the (n+2)-th rising edge that samples bus_as high. A value of 14 raises ack after the first such edge. A value of 15 never raises ack. Once raised, ack stays high while bus_as stays high and the match holds. ack_wide is high when the winning channel is in pin mode 11.
- R9: When several channels match, each one asserts its own cs_n. The ack timing, ack_wide and avec_req all come from the lowest-numbered matching channel.
- R10: A write is captured at the rising edge where cfg_we is high. cfg_sel 00 writes the pin mode, 01 the base register, 10 the option register (bits 14:0) and 11 the port data register, for which cfg_ch is ignored. Only the channel that cfg_ch addresses changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 4 | Channel addressed by the write |
| cfg_sel | input | 2 | Register selector: pin mode, base, option, port data |
| cfg_data | input | 16 | Write data |
| bus_addr | input | 13 | Address bits 23:11 of the current bus cycle |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rw | input | 1 | 1 for read, 0 for write |
| bus_upper | input | 1 | Upper byte lane accessed |
| bus_lower | input | 1 | Lower byte lane accessed |
| bus_cpu | input | 1 | CPU-space cycle |
| bus_super | input | 1 | Supervisor cycle |
| bus_ipl | input | 3 | Interrupt level of a CPU-space cycle |
| cs_n | output | 12 | Active-low selects, one per channel |
| disc_out | output | 12 | Discrete output values for pins in mode 00 |
| ack | output | 1 | Internal transfer acknowledge |
| ack_wide | output | 1 | The acknowledged port is 16 bits wide |
| avec_req | output | 1 | Autovector request |

## Verification
The boot channel is run straight out of reset. A run inside its 1M window against one just past it shows that the reset defaults decode. Programmed channels then see pairs of cycles that differ in one qualifier at a time: an address one block beyond the base, a lane the channel does not take, a direction it refuses, user against supervisor, and a matching against a non-matching interrupt level. Each pair separates the base compare from the lane, direction and space checks. Termination codes of fast, 0, 2, 13 and external each give a different ack cycle. The bench also checks one cycle that hits two overlapping channels, a strobe channel that waits for the data strobe, and pins moved to discrete mode. These show the priority rule, the strobe choice and the port data path.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
   localparam int CFG_W   = 16;
   localparam int BLK_LO  = 11;
   localparam int BLK_FLD = 3;

   typedef enum logic [1:0] {
      PIN_DISC  = 2'b00,
      PIN_ALT   = 2'b01,
      PIN_SEL8  = 2'b10,
      PIN_SEL16 = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      CFG_PIN  = 2'b00,
      CFG_BASE = 2'b01,
      CFG_OPT  = 2'b10,
      CFG_PORT = 2'b11
   } cfg_sel_e;

   // option word without its unused top bit
   typedef struct packed {
      logic [1:0] lanes;
      logic [1:0] dir;
      logic       ds_time;
      logic [3:0] term;
      logic [1:0] space;
      logic [2:0] ipl;
      logic       avec;
   } opt_t;

   localparam logic [3:0] TERM_FAST = 4'd14;
   localparam logic [3:0] TERM_EXT  = 4'd15;

   // lowest compared address bit for a block size code
   function automatic int blk_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 11;
         3'd1:    return 13;
         3'd2:    return 14;
         3'd3:    return 16;
         3'd4:    return 17;
         3'd5:    return 18;
         3'd6:    return 19;
         default: return 20;
      endcase
   endfunction
endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs import csel_pkg::*; #(
   parameter int          NCH       = 12,
   parameter int          CH_W      = 4,
   parameter logic [1:0]  BOOT_PIN  = 2'b11,
   parameter logic [15:0] BOOT_BASE = 16'h0007,
   parameter logic [14:0] BOOT_OPT  = 15'h7B70
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [CH_W-1:0]        cfg_ch,
   input  logic [1:0]             cfg_sel,
   input  logic [CFG_W-1:0]       cfg_data,
   output logic [NCH-1:0][1:0]    pin_o,
   output logic [NCH-1:0][CFG_W-1:0] base_o,
   output opt_t [NCH-1:0]         opt_o,
   output logic [NCH-1:0]         port_o
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [1:0]       PIN_RST  = (g == 0) ? BOOT_PIN  : 2'b00;
      localparam logic [CFG_W-1:0] BASE_RST = (g == 0) ? BOOT_BASE : '0;
      localparam logic [14:0]      OPT_RST  = (g == 0) ? BOOT_OPT  : '0;

      logic             wr;
      logic [1:0]       pin_q;
      logic [CFG_W-1:0] base_q;
      opt_t             opt_q;

      assign wr = cfg_we && (cfg_ch == CH_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q  <= PIN_RST;
            base_q <= BASE_RST;
            opt_q  <= opt_t'(OPT_RST);
         end else if (wr) begin
            case (cfg_sel)
               CFG_PIN:  pin_q  <= cfg_data[1:0];
               CFG_BASE: base_q <= cfg_data;
               CFG_OPT:  opt_q  <= opt_t'(cfg_data[14:0]);
               default:  ;
            endcase
         end
      end

      assign pin_o[g]  = pin_q;
      assign base_o[g] = base_q;
      assign opt_o[g]  = opt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         port_o <= '0;
      else if (cfg_we && cfg_sel == CFG_PORT)
         port_o <= cfg_data[NCH-1:0];
   end
endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match import csel_pkg::*; #(
   parameter int ADDR_W = 24
) (
   input  logic                   sel_en,
   input  logic [CFG_W-1:0]       base_i,
   input  logic [1:0]             lanes,
   input  logic [1:0]             dir,
   input  logic                   ds_time,
   input  logic [1:0]             space,
   input  logic [2:0]             ipl,
   input  logic [ADDR_W-1:BLK_LO] bus_addr,
   input  logic                   bus_as,
   input  logic                   bus_ds,
   input  logic                   bus_rw,
   input  logic                   bus_upper,
   input  logic                   bus_lower,
   input  logic                   bus_cpu,
   input  logic                   bus_super,
   input  logic [2:0]             bus_ipl,
   output logic                   hit,
   output logic                   drive
);
   int   shift;
   logic addr_ok, lane_ok, dir_ok, space_ok;

   always_comb begin
      shift   = blk_shift(base_i[BLK_FLD-1:0]);
      addr_ok = 1'b1;
      for (int i = BLK_LO; i < ADDR_W; i++) begin
         if (i >= shift && bus_addr[i] != base_i[i - BLK_LO + BLK_FLD])
            addr_ok = 1'b0;
      end
   end

   always_comb begin
      case (lanes)
         2'b01:   lane_ok = bus_lower;
         2'b10:   lane_ok = bus_upper;
         2'b11:   lane_ok = bus_lower | bus_upper;
         default: lane_ok = 1'b0;
      endcase
      case (dir)
         2'b01:   dir_ok = bus_rw;
         2'b10:   dir_ok = ~bus_rw;
         2'b11:   dir_ok = 1'b1;
         default: dir_ok = 1'b0;
      endcase
      case (space)
         2'b00:   space_ok = bus_cpu && (ipl == 3'd0 || ipl == bus_ipl);
         2'b01:   space_ok = ~bus_cpu & ~bus_super;
         2'b10:   space_ok = ~bus_cpu & bus_super;
         default: space_ok = ~bus_cpu;
      endcase
   end

   assign hit   = sel_en & addr_ok & lane_ok & dir_ok & space_ok;
   assign drive = hit & (ds_time ? bus_ds : bus_as);
endmodule

// File: rtl/csel_term.sv
`timescale 1ns/1ps
module csel_term import csel_pkg::*; #(
   parameter int NCH    = 12,
   parameter int WCNT_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_as,
   input  logic                 bus_cpu,
   input  logic [NCH-1:0]       hit,
   input  logic [NCH-1:0]       wide_en,
   input  logic [NCH-1:0][3:0]  term_i,
   input  logic [NCH-1:0]       avec_en,
   output logic                 ack,
   output logic                 ack_wide,
   output logic                 avec_req
);
   logic              win_any, win_wide, win_avec, done;
   logic [3:0]        win_term;
   logic [WCNT_W-1:0] wcnt;

   // lowest index wins
   always_comb begin
      win_any  = 1'b0;
      win_wide = 1'b0;
      win_avec = 1'b0;
      win_term = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (hit[i]) begin
            win_any  = 1'b1;
            win_wide = wide_en[i];
            win_avec = avec_en[i];
            win_term = term_i[i];
         end
      end
   end

   always_comb begin
      if (!win_any || win_term == TERM_EXT)
         done = 1'b0;
      else if (win_term == TERM_FAST)
         done = 1'b1;
      else
         done = (WCNT_W'(win_term) + WCNT_W'(1)) <= wcnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt     <= '0;
         ack      <= 1'b0;
         ack_wide <= 1'b0;
         avec_req <= 1'b0;
      end else begin
         if (!bus_as)
            wcnt <= '0;
         else if (wcnt != '1)
            wcnt <= wcnt + 1'b1;
         ack      <= bus_as & done;
         ack_wide <= bus_as & win_any & win_wide;
         avec_req <= bus_as & win_any & win_avec & bus_cpu;
      end
   end
endmodule

// File: rtl/csel_unit.sv
`timescale 1ns/1ps
module csel_unit import csel_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter int NCH    = 12,
   parameter int CH_W   = 4,
   parameter int WCNT_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [CH_W-1:0]        cfg_ch,
   input  logic [1:0]             cfg_sel,
   input  logic [CFG_W-1:0]       cfg_data,
   input  logic [ADDR_W-1:BLK_LO] bus_addr,
   input  logic                   bus_as,
   input  logic                   bus_ds,
   input  logic                   bus_rw,
   input  logic                   bus_upper,
   input  logic                   bus_lower,
   input  logic                   bus_cpu,
   input  logic                   bus_super,
   input  logic [2:0]             bus_ipl,
   output logic [NCH-1:0]         cs_n,
   output logic [NCH-1:0]         disc_out,
   output logic                   ack,
   output logic                   ack_wide,
   output logic                   avec_req
);
   localparam int CMP_BITS = ADDR_W - BLK_LO;

   initial begin : elab_chk
      if (CMP_BITS != CFG_W - BLK_FLD)
         $fatal(1, "ADDR_W does not fit the base register");
      if (NCH < 1 || NCH > CFG_W || NCH > (1 << CH_W))
         $fatal(1, "NCH out of range for CH_W or port width");
      if ((1 << WCNT_W) - 1 < 15)
         $fatal(1, "WCNT_W too small for 13 wait states");
   end

   logic [NCH-1:0][1:0]       pin_q;
   logic [NCH-1:0][CFG_W-1:0] base_q;
   opt_t [NCH-1:0]            opt_q;
   logic [NCH-1:0]            port_q;
   logic [NCH-1:0]            sel_mask, disc_mask, wide_mask, avec_mask;
   logic [NCH-1:0][3:0]       term_a;
   logic [NCH-1:0]            hit, drive;

   csel_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .pin_o(pin_q), .base_o(base_q), .opt_o(opt_q), .port_o(port_q)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_dec
      assign sel_mask[g]  = pin_q[g][1];
      assign wide_mask[g] = pin_q[g] == PIN_SEL16;
      assign disc_mask[g] = pin_q[g] == PIN_DISC;
      assign avec_mask[g] = opt_q[g].avec;
      assign term_a[g]    = opt_q[g].term;

      csel_match #(.ADDR_W(ADDR_W)) u_match (
         .sel_en(sel_mask[g]), .base_i(base_q[g]),
         .lanes(opt_q[g].lanes), .dir(opt_q[g].dir),
         .ds_time(opt_q[g].ds_time), .space(opt_q[g].space),
         .ipl(opt_q[g].ipl), .bus_addr(bus_addr),
         .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
         .bus_upper(bus_upper), .bus_lower(bus_lower),
         .bus_cpu(bus_cpu), .bus_super(bus_super), .bus_ipl(bus_ipl),
         .hit(hit[g]), .drive(drive[g])
      );
   end

   csel_term #(.NCH(NCH), .WCNT_W(WCNT_W)) u_term (
      .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_cpu(bus_cpu),
      .hit(hit), .wide_en(wide_mask), .term_i(term_a), .avec_en(avec_mask),
      .ack(ack), .ack_wide(ack_wide), .avec_req(avec_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cs_n <= '1;
      else
         cs_n <= ~drive;
   end

   assign disc_out = port_q & disc_mask;
endmodule

// File: rtl/csel_chk.sv
`timescale 1ns/1ps
module csel_chk #(
   parameter int NCH = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_as,
   input logic           bus_ds,
   input logic           bus_cpu,
   input logic [NCH-1:0] cs_n,
   input logic [NCH-1:0] sel_mask,
   input logic           ack,
   input logic           ack_wide,
   input logic           avec_req
);
   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as && !bus_ds) |=> (&cs_n)); // R7

   AST_NONSEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (&(cs_n | $past(sel_mask)))); // R2

   AST_ACK_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(bus_as)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as |=> (!ack && !ack_wide && !avec_req)); // R8

   AST_AVEC_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      avec_req |-> $past(bus_cpu)); // R6
endmodule

bind csel_unit csel_chk #(.NCH(NCH)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_ds(bus_ds),
   .bus_cpu(bus_cpu), .cs_n(cs_n), .sel_mask(sel_mask),
   .ack(ack), .ack_wide(ack_wide), .avec_req(avec_req)
);

// File: tb/test_csel_unit.sv
`timescale 1ns/1ps
module test_csel_unit;
   localparam int CLK_P = 10;
   localparam int NCH   = 12;
   localparam int LEN   = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic [23:11] bus_addr = '0;
   logic        bus_as = 1'b0, bus_ds = 1'b0, bus_rw = 1'b1;
   logic        bus_upper = 1'b0, bus_lower = 1'b0;
   logic        bus_cpu = 1'b0, bus_super = 1'b0;
   logic [2:0]  bus_ipl = '0;
   logic [NCH-1:0] cs_n, disc_out;
   logic        ack, ack_wide, avec_req;

   int checks = 0;
   int failures = 0;

   typedef struct {
      string          req;
      logic [NCH-1:0] cs0;
      logic [NCH-1:0] csl;
      int             ackc;
      logic           wide;
      logic           avec;
   } exp_t;
   exp_t expq[$];

   always #(CLK_P/2) clk = ~clk;

   csel_unit i_csel_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .bus_addr(bus_addr),
      .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
      .bus_upper(bus_upper), .bus_lower(bus_lower), .bus_cpu(bus_cpu),
      .bus_super(bus_super), .bus_ipl(bus_ipl), .cs_n(cs_n),
      .disc_out(disc_out), .ack(ack), .ack_wide(ack_wide), .avec_req(avec_req)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_cfg(input int ch, input logic [1:0] sel, input logic [15:0] data);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_sel = sel; cfg_data = data;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // driver: pushes the expected item, then runs one bus cycle
   task automatic bus_cycle(input string req, input logic [23:0] addr,
                            input logic rw, input logic up, input logic lo,
                            input logic cpu, input logic sup, input logic [2:0] ipl,
                            input logic [NCH-1:0] cs0, input logic [NCH-1:0] csl,
                            input int ackc, input logic wide, input logic avec);
      exp_t e;
      e.req = req; e.cs0 = cs0; e.csl = csl; e.ackc = ackc; e.wide = wide; e.avec = avec;
      expq.push_back(e);
      @(posedge clk); #1;
      bus_addr = addr[23:11]; bus_rw = rw; bus_upper = up; bus_lower = lo;
      bus_cpu = cpu; bus_super = sup; bus_ipl = ipl; bus_as = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      bus_ds = 1'b1;
      repeat (LEN - 1) @(posedge clk);
      #1;
      bus_as = 1'b0; bus_ds = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   // monitor: pops the expected item and compares across the cycle
   initial begin : monitor
      forever begin
         exp_t e;
         int first_ack;
         @(posedge bus_as);
         e = expq.pop_front();
         first_ack = -1;
         @(negedge clk);
         for (int c = 0; c < LEN; c++) begin
            @(negedge clk);
            if (ack && first_ack < 0) first_ack = c;
            if (c == 0) check(e.req, "cs_n first cycle", int'(cs_n), int'(e.cs0));
            if (c == LEN - 1) begin
               check(e.req, "cs_n late", int'(cs_n), int'(e.csl));
               check(e.req, "ack_wide", int'(ack_wide), int'(e.wide));
               check(e.req, "avec_req", int'(avec_req), int'(e.avec));
            end
         end
         check(e.req, "ack cycle", first_ack, e.ackc);
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset cs_n", int'(cs_n), 12'hFFF);
      check("R1", "reset ack", int'(ack), 0);
      check("R1", "reset disc_out", int'(disc_out), 0);
      check("R1", "reset ack_wide/avec", int'({ack_wide, avec_req}), 0);

      // R1 boot channel defaults, R8 13 waits -> ack cycle 14, R3 1M window
      bus_cycle("R1", 24'h012345, 1, 1, 1, 0, 0, 0, 12'hFFE, 12'hFFE, 14, 1, 0);
      bus_cycle("R3", 24'h100000, 1, 1, 1, 0, 0, 0, 12'hFFF, 12'hFFF, -1, 0, 0);

      // ch1: 8-bit, base 0x200000 64K, both lanes, read only, fast, user+super
      wr_cfg(1, 2'b00, 16'h0002);
      wr_cfg(1, 2'b01, 16'h2003);
      wr_cfg(1, 2'b10, 16'h6BB0);
      bus_cycle("R8", 24'h20FFFE, 1, 1, 1, 0, 0, 0, 12'hFFD, 12'hFFD, 0, 0, 0);
      bus_cycle("R3", 24'h210000, 1, 1, 1, 0, 0, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      bus_cycle("R5", 24'h200010, 0, 1, 1, 0, 0, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      bus_cycle("R4", 24'h200000, 1, 1, 0, 0, 1, 0, 12'hFFD, 12'hFFD, 0, 0, 0);

      // ch2: 16-bit, base 0x300000 2K, upper lane, R/W, data strobe, 2 waits, supervisor
      wr_cfg(2, 2'b00, 16'h0003);
      wr_cfg(2, 2'b01, 16'h3000);
      wr_cfg(2, 2'b10, 16'h5CA0);
      bus_cycle("R7", 24'h3007FF, 0, 1, 0, 0, 1, 0, 12'hFFF, 12'hFFB, 3, 1, 0);
      bus_cycle("R4", 24'h3007FF, 0, 0, 1, 0, 1, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      bus_cycle("R6", 24'h3007FF, 0, 1, 0, 0, 0, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      bus_cycle("R3", 24'h300800, 0, 1, 0, 0, 1, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      // R10: ch1 unchanged by ch2 writes
      bus_cycle("R10", 24'h200100, 1, 0, 1, 0, 1, 0, 12'hFFD, 12'hFFD, 0, 0, 0);

      // ch3: 8-bit, base 0xFF0000 64K, CPU space level 5, external term, autovector
      wr_cfg(3, 2'b00, 16'h0002);
      wr_cfg(3, 2'b01, 16'hFF03);
      wr_cfg(3, 2'b10, 16'h7BCB);
      bus_cycle("R6", 24'hFF0010, 1, 1, 1, 1, 1, 5, 12'hFF7, 12'hFF7, -1, 0, 1);
      bus_cycle("R6", 24'hFF0010, 1, 1, 1, 1, 1, 4, 12'hFFF, 12'hFFF, -1, 0, 0);
      bus_cycle("R6", 24'hFF0010, 1, 1, 1, 0, 1, 5, 12'hFFF, 12'hFFF, -1, 0, 0);
      // any level, 0 waits, no autovector
      wr_cfg(3, 2'b10, 16'h7800);
      bus_cycle("R8", 24'hFF0010, 1, 1, 1, 1, 1, 6, 12'hFF7, 12'hFF7, 1, 0, 0);

      // ch4 overlaps boot: 8-bit, base 0 2K, fast; boot (lower index) wins
      wr_cfg(4, 2'b00, 16'h0002);
      wr_cfg(4, 2'b01, 16'h0000);
      wr_cfg(4, 2'b10, 16'h7BB0);
      bus_cycle("R9", 24'h000100, 1, 1, 1, 0, 0, 0, 12'hFEE, 12'hFEE, 14, 1, 0);

      // R2: ch1 to discrete mode, no select, port data drives disc_out
      wr_cfg(1, 2'b00, 16'h0000);
      bus_cycle("R2", 24'h200000, 1, 1, 1, 0, 0, 0, 12'hFFF, 12'hFFF, -1, 0, 0);
      wr_cfg(9, 2'b11, 16'h0FF2);
      @(negedge clk);
      check("R2", "disc_out discrete pins", int'(disc_out), 12'hFE2);
      wr_cfg(5, 2'b00, 16'h0001);
      @(negedge clk);
      check("R2", "disc_out alt pin", int'(disc_out), 12'hFC2);

      repeat (4) @(posedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule